// File: doc/BRIEF.md
# Linked-List DMA Descriptor Walker

This block is the front end of one DMA channel that runs from a chain of descriptors held in memory. A pulse on `start_i` loads the head pointer. The block then fetches a 64-byte descriptor as eight 64-bit reads over a simple request/response read port and decodes the descriptor. It hands the data mover a source address, a destination address, an item count, transfer widths and burst sizes, with a one-cycle start pulse.

The block then waits for the mover's done pulse and raises a block-done event. When the descriptor asks for it, the block also raises a block interrupt request. It then follows the next pointer, or it finishes the chain. A descriptor that is not marked valid, or that carries an illegal width code, stops the walk with an error event and starts no block.

Top module: `ll_desc_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, no read request, mover start or event output is active.
- R2: A `start_i` pulse while idle begins a fetch at `head_ptr_i` with its low 6 bits forced to zero. A `start_i` pulse while a fetch or block is in progress is ignored and does not change any read address.
- R3: A fetch issues eight reads, in ascending order, at base+0, base+8, up to base+56. A request that is not accepted is held with an unchanged address, and requests begin in the cycle after the fetch is launched.
- R4: The descriptor word at byte 0 gives the source address and the word at byte 8 gives the destination address. The word at byte 24 gives the next pointer and the word at byte 32 gives the control word. The words at bytes 40 to 56 have no effect.
- R5: `mv_start_o` is a one-cycle pulse in the cycle after the eighth read response. It is raised only when control bit 63 is set and both width codes are 6 or less. No read is requested while a block runs.
- R6: `mv_items_o` equals bits 21:0 of the word at byte 16, plus one. All higher bits of that word are ignored.
- R7: The source width code is control bits 10:8 and the destination width code is bits 13:11. Codes 0 to 6 give 1 to 64 bytes on `mv_src_bytes_o`/`mv_dst_bytes_o`, where bytes = 2^code. Code 7 on either field makes the descriptor invalid, so R9 applies.
- R8: The source burst code is control bits 17:14 and the destination burst code is bits 21:18. Code 0 gives 1 item and code n>0 gives 2^(n+1) items on `mv_src_burst_o`/`mv_dst_burst_o`.
- R9: When control bit 63 is clear, `desc_err_o` pulses in the cycle after the eighth response instead of `mv_start_o`, and the walker returns to idle.
- R10: `mv_done_i` during a block raises `blk_done_o` for one cycle in the next cycle. `blk_irq_o` pulses with it exactly when control bit 58 was set.
- R11: If control bit 62 is set, `chain_done_o` pulses together with `blk_done_o` and the walker goes idle without using the next pointer. Otherwise the next fetch starts from the next pointer with its low 6 bits cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a chain (honoured only when idle) |
| head_ptr_i | input | AW | First descriptor address |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_addr_o | output | AW | Read byte address (64-bit word) |
| rd_rsp_valid_i | input | 1 | Read data valid (in request order) |
| rd_rsp_data_i | input | 64 | Read data |
| mv_start_o | output | 1 | Start pulse to the data mover |
| mv_src_addr_o | output | AW | Block source address |
| mv_dst_addr_o | output | AW | Block destination address |
| mv_items_o | output | COUNT_W+1 | Items in the block |
| mv_src_bytes_o | output | 7 | Source item size in bytes |
| mv_dst_bytes_o | output | 7 | Destination item size in bytes |
| mv_src_burst_o | output | 17 | Source items per burst |
| mv_dst_burst_o | output | 17 | Destination items per burst |
| mv_done_i | input | 1 | Data mover finished the block |
| blk_done_o | output | 1 | Block completed event |
| blk_irq_o | output | 1 | Block interrupt request event |
| chain_done_o | output | 1 | Last block of chain completed |
| desc_err_o | output | 1 | Invalid descriptor event |

## Verification
The assertions check the following on every cycle:
- a refused read request holds its address, and every read address is word aligned;
- start pulses last one cycle and no fetch overlaps a running block;
- a started block always has legal one-hot item sizes;
- interrupt and chain-done events only appear together with block-done;
- a block-done event always follows a mover done;
- fetching stops after an error or a chain end.

Only the bench scenarios can show the following:
- the decoded field values, and that the mover outputs come from the right descriptor offsets;
- that high size bits, trailing words and pointer low bits are ignored;
- that a start pulse during a chain is dropped;
- that the walk follows the pointers in the right order.

// File: rtl/ll_walk_pkg.sv
package ll_walk_pkg;

    // captured descriptor words, indexed by 64-bit word position
    localparam int unsigned W_SRC     = 0;
    localparam int unsigned W_DST     = 1;
    localparam int unsigned W_SIZE    = 2;
    localparam int unsigned W_NEXT    = 3;
    localparam int unsigned W_CTRL    = 4;
    localparam int unsigned CAP_WORDS = 5;

    // control word bit positions
    localparam int unsigned CB_VALID  = 63;
    localparam int unsigned CB_LAST   = 62;
    localparam int unsigned CB_IRQ    = 58;
    localparam int unsigned CB_SWID   = 8;
    localparam int unsigned CB_DWID   = 11;
    localparam int unsigned CB_SBUR   = 14;
    localparam int unsigned CB_DBUR   = 18;
    localparam int unsigned MAX_WCODE = 6;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_FETCH = 2'd1,
        W_RUN   = 2'd2
    } walk_state_e;

    function automatic logic [6:0] width_bytes(input logic [2:0] code);
        return 7'd1 << code;
    endfunction

    function automatic logic [16:0] burst_items(input logic [3:0] code);
        logic [4:0] sh;
        sh = {1'b0, code} + 5'd1;
        return (code == 4'd0) ? 17'd1 : (17'd1 << sh);
    endfunction

endpackage

// File: rtl/ll_fetch_seq.sv
module ll_fetch_seq #(
    parameter int unsigned AW         = 64,
    parameter int unsigned DESC_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          launch_i,
    input  logic [AW-1:0]                 launch_addr_i,
    output logic                          rd_req_valid_o,
    input  logic                          rd_req_ready_i,
    output logic [AW-1:0]                 rd_addr_o,
    input  logic                          rd_rsp_valid_i,
    output logic                          rsp_take_o,
    output logic [$clog2(DESC_WORDS)-1:0] rsp_idx_o,
    output logic                          fetch_done_o
);
    localparam int unsigned WORD_BYTES = 8;
    localparam int unsigned BYTE_SH    = $clog2(WORD_BYTES);
    localparam int unsigned ALIGN_W    = $clog2(DESC_WORDS * WORD_BYTES);
    localparam int unsigned IDX_W      = $clog2(DESC_WORDS);
    localparam int unsigned CNT_W      = IDX_W + 1;
    localparam logic [AW-1:0] KEEP_MASK = {{(AW-ALIGN_W){1'b1}}, {ALIGN_W{1'b0}}};

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] req_cnt;
        logic [CNT_W-1:0] rsp_cnt;
        logic [AW-1:0]    base;
    } seq_t;

    seq_t s_d, s_q;
    logic req_fire;

    assign rd_req_valid_o = s_q.active && (s_q.req_cnt < CNT_W'(DESC_WORDS));
    assign rd_addr_o      = s_q.base + (AW'(s_q.req_cnt) << BYTE_SH);
    assign req_fire       = rd_req_valid_o && rd_req_ready_i;
    assign rsp_take_o     = s_q.active && rd_rsp_valid_i && (s_q.rsp_cnt < CNT_W'(DESC_WORDS));
    assign rsp_idx_o      = s_q.rsp_cnt[IDX_W-1:0];
    assign fetch_done_o   = rsp_take_o && (s_q.rsp_cnt == CNT_W'(DESC_WORDS - 1));

    always_comb begin
        s_d = s_q;
        if (launch_i) begin
            s_d.active  = 1'b1;
            s_d.req_cnt = '0;
            s_d.rsp_cnt = '0;
            s_d.base    = launch_addr_i & KEEP_MASK;
        end else begin
            if (req_fire) begin
                s_d.req_cnt = s_q.req_cnt + CNT_W'(1);
            end
            if (rsp_take_o) begin
                s_d.rsp_cnt = s_q.rsp_cnt + CNT_W'(1);
                if (fetch_done_o) begin
                    s_d.active = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ll_desc_regs.sv
module ll_desc_regs
    import ll_walk_pkg::*;
#(
    parameter int unsigned AW         = 64,
    parameter int unsigned DESC_WORDS = 8,
    parameter int unsigned COUNT_W    = 22
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          take_i,
    input  logic [$clog2(DESC_WORDS)-1:0] idx_i,
    input  logic [63:0]                   data_i,
    output logic [AW-1:0]                 src_o,
    output logic [AW-1:0]                 dst_o,
    output logic [AW-1:0]                 next_o,
    output logic [COUNT_W:0]              items_o,
    output logic [6:0]                    src_bytes_o,
    output logic [6:0]                    dst_bytes_o,
    output logic [16:0]                   src_burst_o,
    output logic [16:0]                   dst_burst_o,
    output logic                          legal_o,
    output logic                          last_o,
    output logic                          irq_o
);
    localparam int unsigned IDX_W = $clog2(DESC_WORDS);

    logic [CAP_WORDS-1:0][63:0] words;

    for (genvar w = 0; w < CAP_WORDS; w++) begin : g_cap
        logic [63:0] word_d, word_q;
        always_comb begin
            word_d = word_q;
            if (take_i && (idx_i == IDX_W'(w))) begin
                word_d = data_i;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else begin
                word_q <= word_d;
            end
        end
        assign words[w] = word_q;
    end

    logic [63:0] ctl;
    logic [2:0]  swid, dwid;
    logic        unused_hi;

    assign ctl         = words[W_CTRL];
    assign swid        = ctl[CB_SWID +: 3];
    assign dwid        = ctl[CB_DWID +: 3];
    assign src_o       = words[W_SRC][AW-1:0];
    assign dst_o       = words[W_DST][AW-1:0];
    assign next_o      = words[W_NEXT][AW-1:0];
    assign items_o     = {1'b0, words[W_SIZE][COUNT_W-1:0]} + (COUNT_W+1)'(1);
    assign src_bytes_o = width_bytes(swid);
    assign dst_bytes_o = width_bytes(dwid);
    assign src_burst_o = burst_items(ctl[CB_SBUR +: 4]);
    assign dst_burst_o = burst_items(ctl[CB_DBUR +: 4]);
    assign legal_o     = ctl[CB_VALID] && (swid <= 3'(MAX_WCODE)) && (dwid <= 3'(MAX_WCODE));
    assign last_o      = ctl[CB_LAST];
    assign irq_o       = ctl[CB_IRQ];
    assign unused_hi   = ^{words[W_SIZE][63:COUNT_W], ctl[61:59], ctl[57:22], ctl[7:0]};
endmodule

// File: rtl/ll_desc_walker.sv
module ll_desc_walker
    import ll_walk_pkg::*;
#(
    parameter int unsigned AW         = 64,
    parameter int unsigned DESC_WORDS = 8,
    parameter int unsigned COUNT_W    = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [AW-1:0]      head_ptr_i,
    output logic               rd_req_valid_o,
    input  logic               rd_req_ready_i,
    output logic [AW-1:0]      rd_addr_o,
    input  logic               rd_rsp_valid_i,
    input  logic [63:0]        rd_rsp_data_i,
    output logic               mv_start_o,
    output logic [AW-1:0]      mv_src_addr_o,
    output logic [AW-1:0]      mv_dst_addr_o,
    output logic [COUNT_W:0]   mv_items_o,
    output logic [6:0]         mv_src_bytes_o,
    output logic [6:0]         mv_dst_bytes_o,
    output logic [16:0]        mv_src_burst_o,
    output logic [16:0]        mv_dst_burst_o,
    input  logic               mv_done_i,
    output logic               blk_done_o,
    output logic               blk_irq_o,
    output logic               chain_done_o,
    output logic               desc_err_o
);
    localparam int unsigned IDX_W = $clog2(DESC_WORDS);

    typedef struct packed {
        walk_state_e st;
        logic        mv_start;
        logic        blk_done;
        logic        blk_irq;
        logic        chain_done;
        logic        err;
    } walk_t;

    walk_t w_d, w_q;

    logic             launch;
    logic [AW-1:0]    launch_addr;
    logic             rsp_take, fetch_done;
    logic [IDX_W-1:0] rsp_idx;
    logic [AW-1:0]    desc_next;
    logic             desc_legal, desc_last, desc_irq;

    ll_fetch_seq #(.AW(AW), .DESC_WORDS(DESC_WORDS)) u_fetch (
        .clk            (clk),
        .rst_n          (rst_n),
        .launch_i       (launch),
        .launch_addr_i  (launch_addr),
        .rd_req_valid_o (rd_req_valid_o),
        .rd_req_ready_i (rd_req_ready_i),
        .rd_addr_o      (rd_addr_o),
        .rd_rsp_valid_i (rd_rsp_valid_i),
        .rsp_take_o     (rsp_take),
        .rsp_idx_o      (rsp_idx),
        .fetch_done_o   (fetch_done)
    );

    ll_desc_regs #(.AW(AW), .DESC_WORDS(DESC_WORDS), .COUNT_W(COUNT_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (rsp_take),
        .idx_i       (rsp_idx),
        .data_i      (rd_rsp_data_i),
        .src_o       (mv_src_addr_o),
        .dst_o       (mv_dst_addr_o),
        .next_o      (desc_next),
        .items_o     (mv_items_o),
        .src_bytes_o (mv_src_bytes_o),
        .dst_bytes_o (mv_dst_bytes_o),
        .src_burst_o (mv_src_burst_o),
        .dst_burst_o (mv_dst_burst_o),
        .legal_o     (desc_legal),
        .last_o      (desc_last),
        .irq_o       (desc_irq)
    );

    always_comb begin
        w_d            = w_q;
        w_d.mv_start   = 1'b0;
        w_d.blk_done   = 1'b0;
        w_d.blk_irq    = 1'b0;
        w_d.chain_done = 1'b0;
        w_d.err        = 1'b0;
        launch         = 1'b0;
        launch_addr    = head_ptr_i;
        unique case (w_q.st)
            W_IDLE: begin
                if (start_i) begin
                    launch = 1'b1;
                    w_d.st = W_FETCH;
                end
            end
            W_FETCH: begin
                if (fetch_done) begin
                    if (desc_legal) begin
                        w_d.st       = W_RUN;
                        w_d.mv_start = 1'b1;
                    end else begin
                        w_d.st  = W_IDLE;
                        w_d.err = 1'b1;
                    end
                end
            end
            W_RUN: begin
                if (mv_done_i) begin
                    w_d.blk_done = 1'b1;
                    w_d.blk_irq  = desc_irq;
                    if (desc_last) begin
                        w_d.chain_done = 1'b1;
                        w_d.st         = W_IDLE;
                    end else begin
                        launch      = 1'b1;
                        launch_addr = desc_next;
                        w_d.st      = W_FETCH;
                    end
                end
            end
            default: w_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q <= '{st: W_IDLE, default: 1'b0};
        end else begin
            w_q <= w_d;
        end
    end

    assign mv_start_o   = w_q.mv_start;
    assign blk_done_o   = w_q.blk_done;
    assign blk_irq_o    = w_q.blk_irq;
    assign chain_done_o = w_q.chain_done;
    assign desc_err_o   = w_q.err;
endmodule

// File: rtl/ll_desc_walker_chk.sv
module ll_desc_walker_chk #(
    parameter int unsigned AW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_req_valid_o,
    input logic          rd_req_ready_i,
    input logic [AW-1:0] rd_addr_o,
    input logic          mv_start_o,
    input logic [6:0]    mv_src_bytes_o,
    input logic [6:0]    mv_dst_bytes_o,
    input logic          mv_done_i,
    input logic          blk_done_o,
    input logic          blk_irq_o,
    input logic          chain_done_o,
    input logic          desc_err_o
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o && !rd_req_ready_i |=> rd_req_valid_o && $stable(rd_addr_o));

    p_word_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid_o |-> rd_addr_o[2:0] == 3'b000);

    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start_o |=> !mv_start_o);

    p_no_fetch_in_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start_o |-> !rd_req_valid_o);

    p_width_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start_o |-> ($countones(mv_src_bytes_o) == 1) && ($countones(mv_dst_bytes_o) == 1)
                       && !mv_src_bytes_o[6] && !mv_dst_bytes_o[6] || mv_start_o &&
                       (mv_src_bytes_o == 7'd64 || mv_dst_bytes_o == 7'd64));

    p_err_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        desc_err_o |=> !rd_req_valid_o && !mv_start_o);

    p_blk_follows_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done_o |-> $past(mv_done_i));

    p_irq_with_blk_r10: assert property (@(posedge clk) disable iff (!rst_n)
        blk_irq_o |-> blk_done_o);

    p_chain_with_blk_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done_o |-> blk_done_o);

    p_chain_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done_o |=> !rd_req_valid_o);
endmodule

bind ll_desc_walker ll_desc_walker_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rd_req_valid_o (rd_req_valid_o),
    .rd_req_ready_i (rd_req_ready_i),
    .rd_addr_o      (rd_addr_o),
    .mv_start_o     (mv_start_o),
    .mv_src_bytes_o (mv_src_bytes_o),
    .mv_dst_bytes_o (mv_dst_bytes_o),
    .mv_done_i      (mv_done_i),
    .blk_done_o     (blk_done_o),
    .blk_irq_o      (blk_irq_o),
    .chain_done_o   (chain_done_o),
    .desc_err_o     (desc_err_o)
);

// File: tb/tb_ll_desc_walker.sv
`timescale 1ns/1ps
module tb_ll_desc_walker;
    localparam int AW      = 64;
    localparam int COUNT_W = 22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic              start_i = 1'b0;
    logic [AW-1:0]     head_ptr_i = '0;
    logic              rd_req_valid_o, rd_req_ready_i = 1'b0;
    logic [AW-1:0]     rd_addr_o;
    logic              rd_rsp_valid_i = 1'b0;
    logic [63:0]       rd_rsp_data_i = '0;
    logic              mv_start_o;
    logic [AW-1:0]     mv_src_addr_o, mv_dst_addr_o;
    logic [COUNT_W:0]  mv_items_o;
    logic [6:0]        mv_src_bytes_o, mv_dst_bytes_o;
    logic [16:0]       mv_src_burst_o, mv_dst_burst_o;
    logic              mv_done_i = 1'b0;
    logic              blk_done_o, blk_irq_o, chain_done_o, desc_err_o;

    ll_desc_walker #(.AW(AW), .DESC_WORDS(8), .COUNT_W(COUNT_W)) dut (.*);

    logic [63:0] mem [logic [63:0]];
    int checks = 0;
    int errors = 0;

    // reference model state
    bit          model_on = 0;
    bit          m_fetch = 0, m_run = 0;
    int          m_issued = 0, m_rcvd = 0;
    logic [63:0] m_ptr = '0;
    logic [63:0] pend_addr [$];
    longint      pend_due [$];
    longint      cyc = 0;
    int          rd_lat = 1, rdy_mode = 0, mv_lat = 0, mv_wait = 0;
    bit          exp_start = 0, exp_err = 0, exp_blk = 0, exp_irq = 0, exp_chain = 0;
    logic [63:0] e_src, e_dst, e_next;
    logic [63:0] e_items, e_sb, e_db, e_sbu, e_dbu;
    bit          e_last = 0, e_ioc = 0;
    bit          start_req = 0;
    logic [63:0] start_ptr = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] rdm(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic logic [63:0] burst_of(input int code);
        return (code == 0) ? 64'd1 : (64'd1 << (code + 1));
    endfunction

    function automatic logic [63:0] mk_ctl(input bit v, input bit l, input bit ioc,
                                           input int sw, input int dw, input int sb, input int db);
        logic [63:0] c;
        c = 64'h0;
        c[63] = v; c[62] = l; c[58] = ioc;
        c[10:8] = 3'(sw); c[13:11] = 3'(dw);
        c[17:14] = 4'(sb); c[21:18] = 4'(db);
        c[7:0] = 8'h5A; c[57:22] = 36'h9_1234_5678;
        return c;
    endfunction

    task automatic put_desc(input logic [63:0] at, input logic [63:0] src, input logic [63:0] dst,
                            input logic [63:0] size, input logic [63:0] nxt, input logic [63:0] ctl);
        mem[at]      = src;
        mem[at + 8]  = dst;
        mem[at + 16] = size;
        mem[at + 24] = nxt;
        mem[at + 32] = ctl;
        mem[at + 40] = 64'hFFFF_FFFF_FFFF_FFFF;
        mem[at + 48] = 64'h0123_4567_89AB_CDEF;
        mem[at + 56] = 64'hDEAD_BEEF_DEAD_BEEF;
    endtask

    task automatic decode_model();
        logic [63:0] ctl;
        bit ok;
        ctl = rdm(m_ptr + 32);
        ok = ctl[63] && (ctl[10:8] <= 3'd6) && (ctl[13:11] <= 3'd6);
        m_fetch = 0;
        if (ok) begin
            exp_start = 1;
            m_run     = 1;
            mv_wait   = mv_lat;
            e_src     = rdm(m_ptr);
            e_dst     = rdm(m_ptr + 8);
            e_items   = 64'(rdm(m_ptr + 16) & 64'h3F_FFFF) + 64'd1;
            e_next    = rdm(m_ptr + 24);
            e_sb      = 64'd1 << ctl[10:8];
            e_db      = 64'd1 << ctl[13:11];
            e_sbu     = burst_of(int'(ctl[17:14]));
            e_dbu     = burst_of(int'(ctl[21:18]));
            e_last    = ctl[62];
            e_ioc     = ctl[58];
        end else begin
            exp_err = 1;
        end
    endtask

    task automatic step();
        bit was_idle;
        bit rdy;
        was_idle = !m_fetch && !m_run;
        // compare this cycle's outputs with the model
        chk("R3 read request valid", 64'(rd_req_valid_o), 64'(m_fetch && m_issued < 8));
        chk("R5 mover start", 64'(mv_start_o), 64'(exp_start));
        chk("R9 descriptor error", 64'(desc_err_o), 64'(exp_err));
        chk("R10 block done", 64'(blk_done_o), 64'(exp_blk));
        chk("R10 block irq", 64'(blk_irq_o), 64'(exp_blk && exp_irq));
        chk("R11 chain done", 64'(chain_done_o), 64'(exp_blk && exp_chain));
        if (exp_start && mv_start_o) begin
            chk("R4 source address", mv_src_addr_o, e_src);
            chk("R4 destination address", mv_dst_addr_o, e_dst);
            chk("R6 item count", 64'(mv_items_o), e_items);
            chk("R7 source bytes", 64'(mv_src_bytes_o), e_sb);
            chk("R7 destination bytes", 64'(mv_dst_bytes_o), e_db);
            chk("R8 source burst", 64'(mv_src_burst_o), e_sbu);
            chk("R8 destination burst", 64'(mv_dst_burst_o), e_dbu);
        end
        exp_start = 0; exp_err = 0; exp_blk = 0; exp_irq = 0; exp_chain = 0;
        // mover
        mv_done_i = 1'b0;
        if (m_run) begin
            if (mv_wait > 0) begin
                mv_wait--;
            end else begin
                mv_done_i = 1'b1;
                m_run     = 0;
                exp_blk   = 1;
                exp_irq   = e_ioc;
                exp_chain = e_last;
                if (!e_last) begin
                    m_fetch  = 1;
                    m_issued = 0;
                    m_rcvd   = 0;
                    m_ptr    = e_next & ~64'h3F;
                end
            end
        end
        // read request side
        rdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        rd_req_ready_i = rdy;
        if (m_fetch && m_issued < 8 && rdy && rd_req_valid_o) begin
            chk("R3 read address (R2 head alignment, R11 next pointer)", rd_addr_o,
                m_ptr + 64'(8 * m_issued));
            pend_addr.push_back(m_ptr + 64'(8 * m_issued));
            pend_due.push_back(cyc + longint'(rd_lat));
            m_issued++;
        end
        // read response side
        rd_rsp_valid_i = 1'b0;
        rd_rsp_data_i  = 64'hBAD0_BAD0_BAD0_BAD0;
        if (pend_addr.size() > 0 && pend_due[0] <= cyc) begin
            rd_rsp_valid_i = 1'b1;
            rd_rsp_data_i  = rdm(pend_addr.pop_front());
            void'(pend_due.pop_front());
            m_rcvd++;
            if (m_rcvd == 8) decode_model();
        end
        // start request
        start_i    = 1'b0;
        head_ptr_i = start_ptr;
        if (start_req) begin
            start_i   = 1'b1;
            start_req = 0;
            if (was_idle) begin
                m_fetch  = 1;
                m_issued = 0;
                m_rcvd   = 0;
                m_ptr    = start_ptr & ~64'h3F;
            end
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (model_on) step();
        end
    end

    task automatic launch(input logic [63:0] head);
        @(posedge clk);
        start_ptr = head;
        start_req = 1;
    endtask

    task automatic wait_idle();
        @(posedge clk);
        while (start_req || m_fetch || m_run) @(posedge clk);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: quiet outputs during reset and right after
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 request in reset", 64'(rd_req_valid_o), 64'h0);
        chk("R1 events in reset", 64'({mv_start_o, blk_done_o, blk_irq_o, chain_done_o, desc_err_o}), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 request after reset", 64'(rd_req_valid_o), 64'h0);
        chk("R1 events after reset", 64'({mv_start_o, blk_done_o, blk_irq_o, chain_done_o, desc_err_o}), 64'h0);
        model_on = 1;

        // single last descriptor, high size bits must be ignored (R6)
        put_desc(64'h1000, 64'hA000_0000_0000_1111, 64'hB000_0000_0000_2222,
                 64'hCAFE_F00D_FFC0_0010, 64'h7777_7777_7777_7740, mk_ctl(1, 1, 1, 2, 3, 0, 3));
        rdy_mode = 0; rd_lat = 1; mv_lat = 2;
        launch(64'h1000);
        wait_idle();

        // three-link chain, misaligned pointers, stalled reads, ignored start (R2)
        put_desc(64'h2000, 64'h10, 64'h20, 64'h5, 64'h3000 | 64'h3F, mk_ctl(1, 0, 0, 0, 6, 15, 1));
        put_desc(64'h3000, 64'h30, 64'h40, 64'h0, 64'h2400, mk_ctl(1, 0, 1, 6, 0, 2, 0));
        put_desc(64'h2400, 64'h50, 64'h60, 64'h003F_FFFF, 64'h9000, mk_ctl(1, 1, 0, 1, 4, 5, 7));
        rdy_mode = 1; rd_lat = 3; mv_lat = 5;
        launch(64'h2000 | 64'h2B);
        repeat (6) @(posedge clk);
        start_ptr = 64'h9000;
        start_req = 1;
        wait_idle();

        // second link invalid: error, no block (R9)
        put_desc(64'h4000, 64'h70, 64'h80, 64'h3, 64'h4040, mk_ctl(1, 0, 1, 0, 0, 0, 0));
        put_desc(64'h4040, 64'h90, 64'hA0, 64'h3, 64'h4000, mk_ctl(0, 1, 1, 0, 0, 0, 0));
        rdy_mode = 0; rd_lat = 2; mv_lat = 0;
        launch(64'h4000);
        wait_idle();

        // illegal destination width code 7 (R7)
        put_desc(64'h5000, 64'h1, 64'h2, 64'h3, 64'h0, mk_ctl(1, 1, 0, 2, 7, 0, 0));
        launch(64'h5000);
        wait_idle();

        // clean run after errors, no irq requested
        put_desc(64'h6000, 64'hFEED, 64'hBEEF, 64'h7, 64'h0, mk_ctl(1, 1, 0, 3, 3, 1, 4));
        rdy_mode = 1; rd_lat = 1; mv_lat = 0;
        launch(64'h6000);
        wait_idle();

        model_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule